// File: doc/BRIEF.md
# Pulse Accumulator with Event and Gated Modes

This timer peripheral keeps an 8-bit accumulator that grows in one of two ways. In event mode it adds one for each chosen edge of an external pulse pin. In gated mode it adds one on each tick of a prescaler while the pin sits at its open-gate level. The prescaler divides the bus-clock enable by 64. A single polarity bit picks the counted edge in event mode. In gated mode the same bit picks the gate level, and the edge that closes the gate raises the input flag.

Software reaches the block through a small register port. Writes take effect at the clock edge and reads are combinational. The port has a control byte, the accumulator, a flag register cleared by writing ones, and an interrupt-enable register. The pin passes through a synchronizer before edge detection. Clearing the enable bit freezes counting and flag setting but leaves the count and flags in place. The other control bits are plain storage that the block does not use. The register port is a plain control port, so it has no valid/ready handshake and no back-pressure.

Top module: `pulse_accum`

## Requirements
- R1: The control register at offset 0 stores all 8 written bits and reads them back. Bit 6 is enable, bit 5 is mode (0 event, 1 gated) and bit 4 is polarity. Every register reads 0 after reset.
- R2: While enable is 0, the accumulator does not count and neither flag can become set.
- R3: Writing enable to 0 leaves the accumulator value and both flags unchanged.
- R4: In event mode, polarity 0 counts falling pin edges and polarity 1 counts rising ones. Each counted edge sets the input flag, which is bit 1 of the flag register at offset 2.
- R5: In gated mode, each prescaler tick adds one while the pin is open-gate: high for polarity 0, low for polarity 1. The prescaler runs freely from reset and ticks on every 64th cycle that has bus_ce set.
- R6: In gated mode, the closing edge of the gate sets the input flag: falling for polarity 0, rising for polarity 1. Pin edges themselves add nothing to the count.
- R7: The accumulator at offset 1 can be read and written. An increment from 0xFF wraps to 0x00 and sets the overflow flag, bit 0 of the flag register. A write in the same cycle as an increment wins, and that increment sets no flag.
- R8: Writing 1 to a flag bit clears it and writing 0 has no effect. A flag set in the same cycle as its clear stays set.
- R9: irq is high when (input flag AND interrupt-enable bit 1) OR (overflow flag AND interrupt-enable bit 0). The interrupt-enable register sits at offset 3, and its bits 7:2 read as 0.
- R10: A pin change takes effect at the third rising clock edge after it. Each edge is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 1 | External pulse / gate pin, asynchronous |
| bus_ce | input | 1 | Bus-clock enable feeding the prescaler |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is an overflow in gated mode. Counting up from zero takes 256 prescaler ticks, which is more than sixteen thousand enabled cycles. The random stimulus gets there by preloading the accumulator near 0xFF while the gate is open. It also rewrites the control byte at random times, so mode and polarity change while the gate or an edge is still in the synchronizer. Directed steps cover the three-edge pin latency and the closing edge of each gate polarity.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;
  localparam logic [ADDR_W-1:0] A_IE   = 2'd3;

  localparam int B_EN    = 6;
  localparam int B_GATED = 5;
  localparam int B_POL   = 4;
  localparam int B_FIN   = 1;
  localparam int B_FOV   = 0;

  typedef struct packed {
    logic en;
    logic gated;
    logic pol;
  } pacc_cfg_t;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  // R10: an edge seen now was preceded by the opposite level one cycle earlier
  a_r10_rise_history: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !$past(lvl));
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  output logic tick
);
  localparam logic [DIV_W-1:0] LAST = '1;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  div_q <= '0;
    else if (ce) div_q <= div_q + 1'b1;
  end

  assign tick = ce && (div_q == LAST);

  // R5: two ticks are never back to back
  a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/pacc_core.sv
module pacc_core
  import pacc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pacc_cfg_t        cfg,
  input  logic             lvl,
  input  logic             rise,
  input  logic             fall,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             clr_in,
  input  logic             clr_ov,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_in,
  output logic             flag_ov
);
  logic flag_edge, gate_open, bump, set_in, set_ov;

  always_comb begin
    flag_edge = cfg.pol ? rise : fall;
    gate_open = cfg.pol ? ~lvl : lvl;
    bump      = cfg.en && (cfg.gated ? (gate_open && tick) : flag_edge);
    set_in    = cfg.en && flag_edge;
    set_ov    = bump && !cnt_we && (cnt_q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flag_in <= 1'b0;
      flag_ov <= 1'b0;
    end else begin
      if (cnt_we)    cnt_q <= cnt_wdata;
      else if (bump) cnt_q <= cnt_q + 1'b1;
      flag_in <= set_in | (flag_in & ~clr_in);
      flag_ov <= set_ov | (flag_ov & ~clr_ov);
    end
  end

  // R2: disabled and not written -> value frozen
  a_r2_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.en && !cnt_we) |=> $stable(cnt_q));
  // R2: flags only rise while enabled
  a_r2_no_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_in) || $rose(flag_ov)) |-> $past(cfg.en));
  // R7: overflow only from a wrap out of all-ones
  a_r7_ovf_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ov) |-> ($past(cnt_q) == '1 && cnt_q == '0));
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pin_in,
  input  logic              bus_ce,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q;
  logic [1:0]        ie_q;
  pacc_cfg_t         cfg;
  logic              lvl, rise, fall, tick;
  logic [CNT_W-1:0]  cnt_q;
  logic              flag_in, flag_ov;
  logic              wr_ctrl, wr_cnt, wr_flag, wr_ie;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cnt  = reg_wr && (reg_addr == A_CNT);
  assign wr_flag = reg_wr && (reg_addr == A_FLAG);
  assign wr_ie   = reg_wr && (reg_addr == A_IE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ie_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (wr_ie)   ie_q   <= reg_wdata[1:0];
    end
  end

  assign cfg = '{en: ctrl_q[B_EN], gated: ctrl_q[B_GATED], pol: ctrl_q[B_POL]};

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .lvl(lvl), .rise(rise), .fall(fall)
  );

  pacc_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .ce(bus_ce), .tick(tick)
  );

  pacc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .lvl(lvl), .rise(rise), .fall(fall),
    .tick(tick), .cnt_we(wr_cnt), .cnt_wdata(reg_wdata[CNT_W-1:0]),
    .clr_in(wr_flag && reg_wdata[B_FIN]), .clr_ov(wr_flag && reg_wdata[B_FOV]),
    .cnt_q(cnt_q), .flag_in(flag_in), .flag_ov(flag_ov)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: reg_rdata = ctrl_q;
      A_CNT:  reg_rdata = DATA_W'(cnt_q);
      A_FLAG: begin
        reg_rdata[B_FIN] = flag_in;
        reg_rdata[B_FOV] = flag_ov;
      end
      default: reg_rdata[1:0] = ie_q;
    endcase
  end

  assign irq = (flag_in & ie_q[1]) | (flag_ov & ie_q[0]);

  // R9: a request needs a pending flag and an enable
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flag_in || flag_ov) && ie_q != 2'b00));
  // R3: clearing enable by itself never changes a flag
  a_r3_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !reg_wdata[B_EN] && ctrl_q[B_EN]) |=> (flag_in || !$past(flag_in)));
endmodule

// File: tb/tb_pulse_accum.sv
module tb_pulse_accum;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic pin_in = 1'b0;
  logic bus_ce = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_accum dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .bus_ce(bus_ce), .irq(irq));

  // expected-state model built from the requirements
  logic [7:0] m_ctrl, m_cnt;
  logic [1:0] m_ie;
  logic m_fin, m_fov, m_s1, m_s2, m_s3;
  logic [5:0] m_pre;

  always @(posedge clk) begin
    logic rz, fl, tk, en, gm, pol, fe, inc, cwe;
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_ie = 0; m_fin = 0; m_fov = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0;
    end else begin
      rz = m_s2 & ~m_s3; fl = ~m_s2 & m_s3;
      tk = bus_ce && (m_pre == 6'd63);
      en = m_ctrl[6]; gm = m_ctrl[5]; pol = m_ctrl[4];
      fe = pol ? rz : fl;
      inc = en && (gm ? ((pol ? ~m_s2 : m_s2) && tk) : fe);
      cwe = reg_wr && reg_addr == 2'd1;
      m_fov = (inc && !cwe && m_cnt == 8'hFF) | (m_fov & ~(reg_wr && reg_addr == 2'd2 && reg_wdata[0]));
      m_fin = (en && fe) | (m_fin & ~(reg_wr && reg_addr == 2'd2 && reg_wdata[1]));
      m_cnt = cwe ? reg_wdata : (inc ? m_cnt + 8'd1 : m_cnt);
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata;
      if (reg_wr && reg_addr == 2'd3) m_ie = reg_wdata[1:0];
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (bus_ce) m_pre = m_pre + 6'd1;
    end
  end

  function automatic logic [7:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_cnt;
      2'd2: return {6'd0, m_fin, m_fov};
      default: return {6'd0, m_ie};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R1";
      2'd1: return "R7";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // compare current outputs against the model, then drive the next cycle
  task automatic cyc(input bit wr, input logic [1:0] a, input logic [7:0] d,
                     input bit pin, input bit ce);
    @(negedge clk);
    chk(tag_of(reg_addr), reg_rdata, model_read(reg_addr));
    chk("R9", {7'd0, irq}, {7'd0, (m_fin & m_ie[1]) | (m_fov & m_ie[0])});
    reg_wr = wr; reg_addr = a; reg_wdata = d; pin_in = pin; bus_ce = ce;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, pin_in, bus_ce);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, reg_addr, 8'd0, pin_in, bus_ce);
  endtask

  task automatic setpin(input bit p);
    cyc(1'b0, reg_addr, 8'd0, p, bus_ce);
    idle(4);
  endtask

  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b0, a, 8'd0, pin_in, bus_ce);
    #1 chk(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 4; a++) peek(a[1:0], 8'h00, "R1");
    wr(2'd0, 8'hD3);                          // enable, event, rising, spare bits
    peek(2'd0, 8'hD3, "R1");
    setpin(1); peek(2'd1, 8'h01, "R4"); peek(2'd2, 8'h02, "R4");
    setpin(0); peek(2'd1, 8'h01, "R4");      // falling not counted
    wr(2'd0, 8'h93);                          // enable off
    peek(2'd1, 8'h01, "R3"); peek(2'd2, 8'h02, "R3");
    wr(2'd2, 8'h02);
    setpin(1); setpin(0);
    peek(2'd1, 8'h01, "R2"); peek(2'd2, 8'h00, "R2");
    wr(2'd0, 8'h40);                          // enable, event, falling
    setpin(1); peek(2'd1, 8'h01, "R4");
    setpin(0); peek(2'd1, 8'h02, "R4"); peek(2'd2, 8'h02, "R4");
    wr(2'd2, 8'h01); peek(2'd2, 8'h02, "R8");
    wr(2'd2, 8'h02); peek(2'd2, 8'h00, "R8");
    wr(2'd1, 8'hFF); peek(2'd1, 8'hFF, "R7");
    setpin(1); setpin(0);
    peek(2'd1, 8'h00, "R7"); peek(2'd2, 8'h03, "R7");
    wr(2'd3, 8'hFD); peek(2'd3, 8'h01, "R9");
    chk("R9", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h01); idle(1); chk("R9", {7'd0, irq}, 8'h00);
    // gated, polarity 0: high pin opens gate
    wr(2'd2, 8'h03); wr(2'd0, 8'h60);
    setpin(1);
    for (int i = 0; i < 128; i++) cyc(1'b0, 2'd1, 8'd0, 1'b1, 1'b1);
    cyc(1'b0, 2'd1, 8'd0, 1'b1, 1'b0);
    #1 chk("R5", reg_rdata, 8'h02);
    peek(2'd2, 8'h00, "R6");
    setpin(0); peek(2'd2, 8'h02, "R6"); peek(2'd1, 8'h02, "R6");
    // gated, polarity 1: low pin opens gate
    wr(2'd2, 8'h02); wr(2'd0, 8'h70);
    for (int i = 0; i < 64; i++) cyc(1'b0, 2'd1, 8'd0, 1'b0, 1'b1);
    cyc(1'b0, 2'd1, 8'd0, 1'b0, 1'b0);
    #1 chk("R5", reg_rdata, 8'h03);
    setpin(1); peek(2'd2, 8'h02, "R6"); peek(2'd1, 8'h03, "R6");
    // R10 latency: event rising
    wr(2'd0, 8'h50); setpin(0);
    cyc(1'b0, 2'd1, 8'd0, 1'b1, 1'b0);
    peek(2'd1, 8'h03, "R10"); peek(2'd1, 8'h03, "R10"); peek(2'd1, 8'h04, "R10");
    idle(4); peek(2'd1, 8'h04, "R10");
    // constrained random against the model
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 40000; i++) begin
      bit w, p, ce;
      logic [1:0] a;
      logic [7:0] d;
      p  = ($urandom % 8 == 0) ? ~pin_in : pin_in;
      ce = ($urandom % 4 != 0);
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      w  = ($urandom % 24 == 0);
      if (w && a == 2'd1 && d[0]) d = 8'hFC | d[1:0];
      if (w && a == 2'd0) d[6] = ($urandom % 6 != 0);
      cyc(w, a, d, p, ce);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule